// File: doc/BRIEF.md
# Dual-Mode Load Extension and Right-Shift Slice

This block is a datapath slice for a 64-bit integer core that can also execute legacy 32-bit programs. A mode input tells the slice whether the machine is in 64-bit mode or in the older 32-bit mode. Each cycle the issue logic may present one operation. The operation is one of two kinds. A load-format operation takes raw data from the memory path and widens it to a full register. A right shift takes a register operand and a shift amount, and the instruction itself says whether it works on 32 or 64 bits.

The slice makes the width decisions that depend on the mode. A 32-bit load is sign-extended in 64-bit mode and zero-extended in 32-bit mode. A 32-bit arithmetic shift copies bit 31 into the upper half. Operations that exist only in 64-bit mode are refused while the machine runs 32-bit code: the slice raises an illegal-instruction flag and produces a zero result. The result, its valid strobe and the trap flag all appear one clock after the operation is issued.

Top module: `dls_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_trap` are 0 after that edge.
- R2: Op code 4 (word load) with `wide_mode`=1 returns `operand[31:0]` with bit 31 copied into bits 63..32.
- R3: Op code 4 (word load) with `wide_mode`=0 returns `operand[31:0]` with bits 63..32 cleared.
- R4: The narrow loads ignore the mode and use only the low byte or halfword of `operand`. Op code 0 sign-extends the byte and op code 1 zero-extends it. Op code 2 sign-extends the halfword and op code 3 zero-extends it.
- R5: Op code 5 (doubleword load) with `wide_mode`=1 returns all 64 bits of `operand` unchanged.
- R6: Op codes 8 (logical) and 9 (arithmetic) shift `operand[31:0]` right by `shamt` modulo 32. Code 8 zero-extends the 32-bit result to 64 bits. Code 9 fills bits 63..32 with result bit 31. Bits 63..32 of `operand` have no effect on either. These shifts are legal in both modes.
- R7: Op codes 10 (logical) and 11 (arithmetic) shift all 64 bits of `operand` right by the full 6-bit `shamt`. Code 11 fills the vacated bits from bit 63.
- R8: Op codes 5, 10 and 11 issued with `wide_mode`=0 set `out_trap`=1 and `out_result`=0.
- R9: `out_valid` equals `in_valid` delayed by one cycle. `out_trap` is only ever 1 together with `out_valid`. A cycle with `in_valid`=0 leaves `out_result` unchanged.
- R10: Op codes 6, 7 and 12 to 15 are reserved. They give `out_result`=0 and `out_trap`=0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| wide_mode | input | 1 | 1 = 64-bit machine mode, 0 = legacy 32-bit mode |
| op_class | input | 4 | Operation code (see R2 to R10) |
| operand | input | 64 | Raw load data or shift source |
| shamt | input | 6 | Right-shift amount |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 64 | Registered result |
| out_trap | output | 1 | Illegal-instruction flag for the reported operation |

## Verification
The bench sends word loads with bit 31 set in both modes. A slice that ignored the mode would extend the same way in both, and one bench check would fail in either case. It issues 32-bit shifts with garbage in the upper operand half and with `shamt` bit 5 set. Both target a slice that leaks upper bits, or one that shifts by the full 6-bit amount and returns zero. It also runs arithmetic shifts at amounts 0, 31 and 63 on negative values to catch sign fill taken from the wrong bit. Finally it issues 64-bit-only operations in 32-bit mode. A slice that forgot the trap, or still wrote a result, would show a nonzero value or a missing flag.

// File: rtl/dls_pkg.sv
// Shared types for the dual-mode load/shift slice.
// Assumes the op code is 4 bits; unlisted codes are reserved.
package dls_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LDB   = 4'd0,
        OP_LDBU  = 4'd1,
        OP_LDH   = 4'd2,
        OP_LDHU  = 4'd3,
        OP_LDW   = 4'd4,
        OP_LDD   = 4'd5,
        OP_SRL32 = 4'd8,
        OP_SRA32 = 4'd9,
        OP_SRL64 = 4'd10,
        OP_SRA64 = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_SHIFT = 2'd1,
        K_RSVD  = 2'd2
    } kind_e;
endpackage

// File: rtl/dls_load_ext.sv
// Load extender: widens byte, halfword, word or doubleword load data to XLEN.
// Assumes XLEN is 64; word loads extend by mode, narrow loads ignore mode.
module dls_load_ext
    import dls_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  op_e             op,
    input  logic            wide_mode,
    input  logic [XLEN-1:0] data,
    output logic [XLEN-1:0] ext
);
    localparam int HALF = XLEN / 2;
    localparam int HW   = 16;
    localparam int BW   = 8;

    // Select the extension rule from the load size, signedness and mode.
    always_comb begin
        unique case (op)
            OP_LDB:  ext = {{(XLEN-BW){data[BW-1]}}, data[BW-1:0]};
            OP_LDBU: ext = {{(XLEN-BW){1'b0}}, data[BW-1:0]};
            OP_LDH:  ext = {{(XLEN-HW){data[HW-1]}}, data[HW-1:0]};
            OP_LDHU: ext = {{(XLEN-HW){1'b0}}, data[HW-1:0]};
            OP_LDW:  ext = {{(XLEN-HALF){wide_mode & data[HALF-1]}}, data[HALF-1:0]};
            OP_LDD:  ext = data;
            default: ext = '0;
        endcase
    end
endmodule

// File: rtl/dls_rshift.sv
// Right shifter of width W, logical or arithmetic on request.
// Assumes W is a power of two; amount is log2(W) bits wide.
module dls_rshift #(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [AW-1:0] amt,
    input  logic          arith,
    output logic [W-1:0]  res
);
    // Shift right, filling vacated bits with the sign bit when arithmetic.
    always_comb begin
        if (arith)
            res = W'($signed(src) >>> amt);
        else
            res = src >> amt;
    end
endmodule

// File: rtl/dls_legal.sv
// Decodes op class into kind and flags ops that need 64-bit mode.
// Assumes the 64-bit-only set is the doubleword load and the 64-bit shifts.
module dls_legal
    import dls_pkg::*;
(
    input  op_e   op,
    input  logic  wide_mode,
    output kind_e kind,
    output logic  illegal
);
    logic wide_only;

    // Classify the op and mark those unavailable in legacy mode.
    always_comb begin
        wide_only = 1'b0;
        unique case (op)
            OP_LDB, OP_LDBU, OP_LDH, OP_LDHU, OP_LDW: kind = K_LOAD;
            OP_LDD: begin
                kind      = K_LOAD;
                wide_only = 1'b1;
            end
            OP_SRL32, OP_SRA32: kind = K_SHIFT;
            OP_SRL64, OP_SRA64: begin
                kind      = K_SHIFT;
                wide_only = 1'b1;
            end
            default: kind = K_RSVD;
        endcase
        illegal = wide_only & ~wide_mode;
    end
endmodule

// File: rtl/dls_unit.sv
// Dual-mode load extension and right-shift slice, one cycle of latency.
// Assumes XLEN = 64 with a 32-bit legacy half; no back-pressure on output.
module dls_unit
    import dls_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     wide_mode,
    input  logic [OP_W-1:0]          op_class,
    input  logic [XLEN-1:0]          operand,
    input  logic [$clog2(XLEN)-1:0]  shamt,
    output logic                     out_valid,
    output logic [XLEN-1:0]          out_result,
    output logic                     out_trap
);
    localparam int HALF = XLEN / 2;
    localparam int SW   = $clog2(XLEN);

    op_e             op;
    kind_e           kind;
    logic            illegal;
    logic [XLEN-1:0] load_val;
    logic [HALF-1:0] sh_narrow;
    logic [XLEN-1:0] sh_wide;
    logic [XLEN-1:0] sh_val;
    logic [XLEN-1:0] next_val;
    logic            is_arith;
    logic            is_narrow_sh;

    assign op = op_e'(op_class);

    dls_legal u_legal (
        .op        (op),
        .wide_mode (wide_mode),
        .kind      (kind),
        .illegal   (illegal)
    );

    dls_load_ext #(.XLEN(XLEN)) u_load (
        .op        (op),
        .wide_mode (wide_mode),
        .data      (operand),
        .ext       (load_val)
    );

    // Shift attributes taken from the op code.
    always_comb begin
        is_arith     = (op == OP_SRA32) || (op == OP_SRA64);
        is_narrow_sh = (op == OP_SRL32) || (op == OP_SRA32);
    end

    dls_rshift #(.W(HALF)) u_sh_narrow (
        .src   (operand[HALF-1:0]),
        .amt   (shamt[SW-2:0]),
        .arith (is_arith),
        .res   (sh_narrow)
    );

    dls_rshift #(.W(XLEN)) u_sh_wide (
        .src   (operand),
        .amt   (shamt),
        .arith (is_arith),
        .res   (sh_wide)
    );

    // Pick the shifter by instruction width and extend the narrow result.
    always_comb begin
        if (is_narrow_sh)
            sh_val = {{(XLEN-HALF){is_arith & sh_narrow[HALF-1]}}, sh_narrow};
        else
            sh_val = sh_wide;
    end

    // Merge by kind; an illegal op produces zero.
    always_comb begin
        unique case (kind)
            K_LOAD:  next_val = load_val;
            K_SHIFT: next_val = sh_val;
            default: next_val = '0;
        endcase
        if (illegal)
            next_val = '0;
    end

    // Output register: valid and trap follow issue, result holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_trap   <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            out_trap  <= in_valid & illegal;
            if (in_valid)
                out_result <= next_val;
        end
    end
endmodule

// File: rtl/dls_checker.sv
// Protocol and mode-rule checker for dls_unit, attached by bind.
// Assumes the default XLEN of 64 and the op codes of dls_pkg.
module dls_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        wide_mode,
    input logic [3:0]  op_class,
    input logic [63:0] operand,
    input logic [5:0]  shamt,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_trap
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_trap));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));

    a_r9_trap_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_valid);

    a_r8_wide_only_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode &&
         (op_class == 4'd5 || op_class == 4'd10 || op_class == 4'd11))
        |=> (out_trap && out_result == 64'd0));

    a_r2_word_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_mode && op_class == 4'd4)
        |=> (out_result == {{32{$past(operand[31])}}, $past(operand[31:0])}));

    a_r3_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && op_class == 4'd4)
        |=> (out_result == {32'd0, $past(operand[31:0])}));

    a_r6_srl32_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd8) |=> (out_result[63:32] == 32'd0));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_class == 4'd6 || op_class == 4'd7 || op_class >= 4'd12))
        |=> (out_result == 64'd0 && !out_trap));
endmodule

bind dls_unit dls_checker u_dls_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .wide_mode  (wide_mode),
    .op_class   (op_class),
    .operand    (operand),
    .shamt      (shamt),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_trap   (out_trap)
);

// File: tb/tb_dls_unit.sv
// Self-checking bench for dls_unit: directed corners plus seeded random ops.
module tb_dls_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        wide_mode;
    logic [3:0]  op_class;
    logic [63:0] operand;
    logic [5:0]  shamt;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_trap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dls_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .wide_mode  (wide_mode),
        .op_class   (op_class),
        .operand    (operand),
        .shamt      (shamt),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_trap   (out_trap)
    );

    function automatic bit exp_trap(input logic wm, input logic [3:0] op);
        return !wm && (op == 4'd5 || op == 4'd10 || op == 4'd11);
    endfunction

    function automatic logic [63:0] exp_val(input logic wm, input logic [3:0] op,
                                            input logic [63:0] d, input logic [5:0] s);
        logic [31:0] lo;
        logic [63:0] r;
        if (exp_trap(wm, op)) return 64'd0;
        case (op)
            4'd0: r = {{56{d[7]}}, d[7:0]};
            4'd1: r = {56'd0, d[7:0]};
            4'd2: r = {{48{d[15]}}, d[15:0]};
            4'd3: r = {48'd0, d[15:0]};
            4'd4: r = wm ? {{32{d[31]}}, d[31:0]} : {32'd0, d[31:0]};
            4'd5: r = d;
            4'd8: begin lo = d[31:0] >> s[4:0]; r = {32'd0, lo}; end
            4'd9: begin lo = 32'($signed(d[31:0]) >>> s[4:0]); r = {{32{lo[31]}}, lo}; end
            4'd10: r = d >> s;
            4'd11: r = 64'($signed(d) >>> s);
            default: r = 64'd0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic wm, input logic [3:0] op);
        if (exp_trap(wm, op)) return "R8";
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: return "R4";
            4'd4: return wm ? "R2" : "R3";
            4'd5: return "R5";
            4'd8, 4'd9: return "R6";
            4'd10, 4'd11: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one op at a falling edge, then check at the next falling edge.
    task automatic run_op(input logic wm, input logic [3:0] op,
                          input logic [63:0] d, input logic [5:0] s);
        string r;
        r = req_of(wm, op);
        in_valid  = 1'b1;
        wide_mode = wm;
        op_class  = op;
        operand   = d;
        shamt     = s;
        @(negedge clk);
        check("R9", "valid", {63'd0, out_valid}, 64'd1);
        check(r, "result", out_result, exp_val(wm, op, d, s));
        check(r, "trap", {63'd0, out_trap}, {63'd0, exp_trap(wm, op)});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] held;
        void'($urandom(32'd2024));
        rst_n = 1'b0; in_valid = 1'b0; wide_mode = 1'b1;
        op_class = 4'd0; operand = '0; shamt = '0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1", "trap in reset", {63'd0, out_trap}, 64'd0);
        // Issue during reset must still leave valid low
        in_valid = 1'b1; op_class = 4'd5; wide_mode = 1'b0;
        @(negedge clk);
        check("R1", "valid with issue in reset", {63'd0, out_valid}, 64'd0);
        check("R1", "trap with issue in reset", {63'd0, out_trap}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3 word load with bit 31 set, both modes
        run_op(1'b1, 4'd4, 64'h1234_5678_8000_0001, 6'd0);
        run_op(1'b0, 4'd4, 64'h1234_5678_8000_0001, 6'd0);
        run_op(1'b1, 4'd4, 64'hFFFF_FFFF_7FFF_FFFF, 6'd0);
        // R4 narrow loads in both modes
        run_op(1'b0, 4'd0, 64'hAAAA_AAAA_AAAA_AA80, 6'd0);
        run_op(1'b1, 4'd1, 64'hAAAA_AAAA_AAAA_AA80, 6'd0);
        run_op(1'b0, 4'd2, 64'h0000_0000_0000_8001, 6'd0);
        run_op(1'b1, 4'd3, 64'hFFFF_FFFF_FFFF_8001, 6'd0);
        // R5 doubleword load
        run_op(1'b1, 4'd5, 64'hDEAD_BEEF_CAFE_F00D, 6'd0);
        // R6 narrow shifts: upper garbage, amount bit 5 set, sign fill
        run_op(1'b1, 4'd9, 64'h5555_5555_8000_0000, 6'd31);
        run_op(1'b0, 4'd9, 64'h0000_0000_8000_0000, 6'd0);
        run_op(1'b1, 4'd8, 64'hFFFF_FFFF_F000_0000, 6'd36);
        run_op(1'b0, 4'd9, 64'hFFFF_FFFF_7000_0000, 6'd33);
        // R7 wide shifts
        run_op(1'b1, 4'd11, 64'h8000_0000_0000_0000, 6'd63);
        run_op(1'b1, 4'd10, 64'h8000_0000_0000_0000, 6'd63);
        run_op(1'b1, 4'd11, 64'h8000_0000_0000_0000, 6'd32);
        // R8 wide-only ops in legacy mode
        run_op(1'b0, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
        run_op(1'b0, 4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 6'd1);
        run_op(1'b0, 4'd11, 64'h8000_0000_0000_0000, 6'd4);
        // R10 reserved codes
        run_op(1'b1, 4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
        run_op(1'b0, 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);

        // R9 idle cycle keeps result, drops valid and trap
        run_op(1'b1, 4'd5, 64'h0123_4567_89AB_CDEF, 6'd0);
        held = 64'h0123_4567_89AB_CDEF;
        in_valid = 1'b0; op_class = 4'd0; operand = '0;
        @(negedge clk);
        check("R9", "idle valid", {63'd0, out_valid}, 64'd0);
        check("R9", "idle trap", {63'd0, out_trap}, 64'd0);
        check("R9", "idle result held", out_result, held);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            run_op(1'($urandom), 4'($urandom_range(0, 15)), d, 6'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule